// File: doc/BRIEF.md
# Two-Wire Debug Link Bring-Up Sequencer

This block sits on the probe side of a two-wire, reduced-pin JTAG link. One wire is a clock that only the probe drives. The other is a shared data line that the probe drives in most bit slots and releases in the slots that belong to the target. After a `start` pulse the sequencer takes the link from an unknown condition to a known scan format by running a fixed script.

The script runs in this order:
1. A reset escape: data toggles while the clock is held high.
2. A run of clocks that forces the target test controller into reset, then one clock that moves it to idle.
3. A selection escape.
4. The activation and extension code nibbles.

A mode input picks between two variants of what follows. The full variant sends a global initialisation field and check packets. It then locks command level two, sends the commands that choose the three-slot-per-bit scan format, and ends with scan-format cycles that leave command level two. The short variant, for targets with a reduced implementation, sends different code nibbles and a check packet, and the three-slot format is in force at once.

A programmable divider sets the link clock rate. `busy_o` marks the run and `done_o` reports that it has completed.

Top module: `link_connect_seq`

## Requirements
- R1: After `start_i`, the first link activity is a reset escape. It consists of RST_TOGGLES data toggles (default 10, at least 8) while `link_clk_o` stays high.
- R2: Next come RST_CLOCKS link clock rising edges (default 22, at least 22) with data 1, then one rising edge with data 0.
- R3: A selection escape of exactly 7 toggles with the clock held high follows the controller-idle clock.
- R4: Full mode (`short_mode_i`=0) then sends the following, each as raw data bits:
  - a 4-bit activation code of 0
  - a 4-bit extension code of 0
  - a 24-bit all-zero initialisation field
  - a 4-bit zero check packet
- R5: Full mode then sends 9-bit command words, each laid out as {arg[4:0], op[3:0]} and sent LSB first, in this order:
  - level lock (op 0, arg 2)
  - sampling edge (op 1, arg 1)
  - scan format (op 3, arg 9)
  - a 4-bit zero check packet
  - mode-control clear (op 7, arg 0)
  - one scan-format bit with TMS 0
  - a 4-bit zero check packet
  - six scan-format bits carrying TMS value 0x1B
- R6: A scan-format bit takes three clock rising edges. The first carries inverted TDI, which is always 1 here. The second carries the TMS bit. In the third slot the probe releases the line (`link_dat_oe_o`=0) for the whole low phase and takes it back at the rising edge.
- R7: Short mode (`short_mode_i`=1) sends the activation nibble 0xC, the extension nibble 0x8 and a zero check packet after the selection escape, and then ends.
- R8: Raw fields go out LSB first, exactly the requested number of bits, one per clock period. Data changes while the clock is high only inside escapes, and the line is never released while the clock is high.
- R9: Every clock low phase lasts `div_i`+1 system cycles, and toggles within an escape are `div_i`+1 cycles apart.
- R10: `busy_o` rises the cycle after an accepted start and falls when the last step completes. At that moment `done_o` rises and stays high until the next accepted start. The two are never high together.
- R11: `start_i` and `short_mode_i` have no effect while `busy_o` is high.
- R12: Out of reset, the outputs are:
  - `busy_o`=0, `done_o`=0
  - `link_clk_o`=1
  - `link_dat_oe_o`=1, `link_dat_o`=0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin the bring-up script when idle |
| short_mode_i | input | 1 | 1 selects the short variant, sampled at start |
| div_i | input | DIV_W | Link half-period minus one, in system cycles |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | Script completed, held until next start |
| link_clk_o | output | 1 | Link clock to target |
| link_dat_o | output | 1 | Link data driven by the probe |
| link_dat_oe_o | output | 1 | Probe drive enable for the data line |

## Verification
The embedded assertions check a set of rules on every cycle:
- the clock stays high through escapes;
- the line is released only while the clock is low;
- clock edges occur only on divider ticks;
- data moves under a high clock only within an escape;
- the busy/done exclusion holds.

The script content can only be shown by the bench scenarios. These cover the order of steps, every field value and bit order, the three-slot scan framing, the length of the reset run in each mode, and the fact that stray starts or mode changes during a run are ignored. The bench decodes the pin activity into a stream of escapes and sampled bits and compares it with a stream built from the requirements.

// File: rtl/lnkseq_pkg.sv
package lnkseq_pkg;

   localparam int FIELD_W  = 32;   // widest raw field
   localparam int CNT_W    = 6;    // bit/toggle counter width
   localparam int IDX_W    = 5;    // script index width
   localparam int SEL_TOG  = 7;    // selection escape toggles
   localparam int NIB_BITS = 4;
   localparam int INIT_BITS = 24;
   localparam int CMD_BITS = 9;    // {arg[4:0], op[3:0]}
   localparam int N_FULL   = 16;
   localparam int N_SHORT  = 7;

   typedef enum logic [1:0] {
      ST_ESC  = 2'd0,
      ST_RAW  = 2'd1,
      ST_SCAN = 2'd2
   } step_kind_e;

   typedef struct packed {
      step_kind_e            kind;
      logic [CNT_W-1:0]      count;
      logic [FIELD_W-1:0]    field;
   } step_t;

   function automatic step_t mk_step(input step_kind_e k, input int n,
                                     input logic [FIELD_W-1:0] f);
      step_t r;
      r.kind  = k;
      r.count = CNT_W'(n);
      r.field = f;
      return r;
   endfunction

   function automatic logic [FIELD_W-1:0] cmd_word(input logic [3:0] op,
                                                   input logic [4:0] arg);
      return {{(FIELD_W-CMD_BITS){1'b0}}, arg, op};
   endfunction

endpackage

// File: rtl/lnkseq_tick.sv
module lnkseq_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (!en_i) begin
         cnt_q  <= div_i;
         tick_o <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q  <= div_i;
         tick_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q - 1'b1;
         tick_o <= 1'b0;
      end
   end

   // ticks are single-cycle when the divider is above zero (R9)
   p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && en_i && div_i != '0 && $stable(div_i)) |=> !tick_o);

endmodule

// File: rtl/lnkseq_script.sv
module lnkseq_script
   import lnkseq_pkg::*;
#(
   parameter int RST_TOGGLES = 10,
   parameter int RST_CLOCKS  = 22
) (
   input  logic             short_i,
   input  logic [IDX_W-1:0] idx_i,
   output step_t            step_o,
   output logic             last_o
);

   localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(N_FULL - 1);
   localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(N_SHORT - 1);

   assign last_o = (idx_i == (short_i ? LAST_SHORT : LAST_FULL));

   always_comb begin
      step_o = mk_step(ST_RAW, NIB_BITS, '0);
      case (idx_i)
         5'd0: step_o = mk_step(ST_ESC, RST_TOGGLES, '0);
         5'd1: step_o = mk_step(ST_RAW, RST_CLOCKS, '1);
         5'd2: step_o = mk_step(ST_RAW, 1, '0);
         5'd3: step_o = mk_step(ST_ESC, SEL_TOG, '0);
         default: begin
            if (short_i) begin
               case (idx_i)
                  5'd4:    step_o = mk_step(ST_RAW, NIB_BITS, FIELD_W'(4'hC));
                  5'd5:    step_o = mk_step(ST_RAW, NIB_BITS, FIELD_W'(4'h8));
                  default: step_o = mk_step(ST_RAW, NIB_BITS, '0);
               endcase
            end else begin
               case (idx_i)
                  5'd6:    step_o = mk_step(ST_RAW, INIT_BITS, '0);
                  5'd8:    step_o = mk_step(ST_RAW, CMD_BITS, cmd_word(4'd0, 5'd2));
                  5'd9:    step_o = mk_step(ST_RAW, CMD_BITS, cmd_word(4'd1, 5'd1));
                  5'd10:   step_o = mk_step(ST_RAW, CMD_BITS, cmd_word(4'd3, 5'd9));
                  5'd12:   step_o = mk_step(ST_RAW, CMD_BITS, cmd_word(4'd7, 5'd0));
                  5'd13:   step_o = mk_step(ST_SCAN, 1, '0);
                  5'd15:   step_o = mk_step(ST_SCAN, 6, FIELD_W'(6'h1B));
                  default: step_o = mk_step(ST_RAW, NIB_BITS, '0);
               endcase
            end
         end
      endcase
   end

endmodule

// File: rtl/lnkseq_engine.sv
module lnkseq_engine
   import lnkseq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick_i,
   input  logic  load_i,
   input  step_t step_i,
   output logic  done_o,
   output logic  link_clk_o,
   output logic  link_dat_o,
   output logic  link_oe_o
);

   step_kind_e          kind_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [FIELD_W-1:0]  sh_q;
   logic                phase_q;
   logic [1:0]          slot_q;
   logic                run_q;
   logic                clk_q, dat_q, oe_q, done_q;
   logic                last_unit;

   assign last_unit  = (cnt_q == CNT_W'(1));
   assign done_o     = done_q;
   assign link_clk_o = clk_q;
   assign link_dat_o = dat_q;
   assign link_oe_o  = oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= ST_ESC;
         cnt_q   <= '0;
         sh_q    <= '0;
         phase_q <= 1'b0;
         slot_q  <= 2'd0;
         run_q   <= 1'b0;
         clk_q   <= 1'b1;
         dat_q   <= 1'b0;
         oe_q    <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_i) begin
            kind_q  <= step_i.kind;
            cnt_q   <= step_i.count;
            sh_q    <= step_i.field;
            phase_q <= 1'b0;
            slot_q  <= 2'd0;
            run_q   <= 1'b1;
         end else if (tick_i && run_q) begin
            case (kind_q)
               ST_ESC: begin
                  // toggle under a high clock
                  clk_q <= 1'b1;
                  oe_q  <= 1'b1;
                  dat_q <= ~dat_q;
                  if (last_unit) begin
                     run_q  <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
               ST_RAW: begin
                  if (!phase_q) begin
                     clk_q   <= 1'b0;
                     dat_q   <= sh_q[0];
                     oe_q    <= 1'b1;
                     phase_q <= 1'b1;
                  end else begin
                     clk_q   <= 1'b1;
                     sh_q    <= sh_q >> 1;
                     phase_q <= 1'b0;
                     if (last_unit) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                     end else begin
                        cnt_q <= cnt_q - 1'b1;
                     end
                  end
               end
               default: begin
                  if (!phase_q) begin
                     clk_q   <= 1'b0;
                     phase_q <= 1'b1;
                     case (slot_q)
                        2'd0: begin dat_q <= 1'b1;    oe_q <= 1'b1; end
                        2'd1: begin dat_q <= sh_q[0]; oe_q <= 1'b1; end
                        default: oe_q <= 1'b0;
                     endcase
                  end else begin
                     clk_q   <= 1'b1;
                     oe_q    <= 1'b1;
                     phase_q <= 1'b0;
                     if (slot_q == 2'd2) begin
                        slot_q <= 2'd0;
                        sh_q   <= sh_q >> 1;
                        if (last_unit) begin
                           run_q  <= 1'b0;
                           done_q <= 1'b1;
                        end else begin
                           cnt_q <= cnt_q - 1'b1;
                        end
                     end else begin
                        slot_q <= slot_q + 1'b1;
                     end
                  end
               end
            endcase
         end
      end
   end

   // clock stays high through an escape
   p_esc_clk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && kind_q == ST_ESC) |-> clk_q);

   // line released only with the clock low
   p_release_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_q |-> !clk_q);

   // data moves under a high clock only within an escape
   p_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(dat_q) && clk_q && $past(clk_q)) |-> $past(run_q && kind_q == ST_ESC));

   // clock edges only on divider ticks
   p_edge_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_q) |-> $past(tick_i));

endmodule

// File: rtl/link_connect_seq.sv
module link_connect_seq
   import lnkseq_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int RST_TOGGLES = 10,
   parameter int RST_CLOCKS  = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             short_mode_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             link_clk_o,
   output logic             link_dat_o,
   output logic             link_dat_oe_o
);

   if (DIV_W < 1) begin : g_chk_div
      $error("DIV_W must be at least 1");
   end
   if (RST_TOGGLES < 8 || RST_TOGGLES >= (1 << CNT_W)) begin : g_chk_esc
      $error("RST_TOGGLES must be >= 8 and fit the counter");
   end
   if (RST_CLOCKS < 22 || RST_CLOCKS > FIELD_W) begin : g_chk_rst
      $error("RST_CLOCKS must lie in 22..FIELD_W");
   end

   typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT} sq_e;

   sq_e              state_q;
   logic             mode_q;
   logic [IDX_W-1:0] idx_q;
   logic             tick;
   logic             eng_done;
   logic             is_last;
   step_t            cur_step;

   lnkseq_tick #(.DIV_W(DIV_W)) i_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (busy_o),
      .div_i  (div_i),
      .tick_o (tick)
   );

   lnkseq_script #(.RST_TOGGLES(RST_TOGGLES), .RST_CLOCKS(RST_CLOCKS)) i_script (
      .short_i (mode_q),
      .idx_i   (idx_q),
      .step_o  (cur_step),
      .last_o  (is_last)
   );

   lnkseq_engine i_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .load_i     (state_q == SQ_LOAD),
      .step_i     (cur_step),
      .done_o     (eng_done),
      .link_clk_o (link_clk_o),
      .link_dat_o (link_dat_o),
      .link_oe_o  (link_dat_oe_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         mode_q  <= 1'b0;
         idx_q   <= '0;
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  mode_q  <= short_mode_i;
                  idx_q   <= '0;
                  busy_o  <= 1'b1;
                  done_o  <= 1'b0;
                  state_q <= SQ_LOAD;
               end
            end
            SQ_LOAD: state_q <= SQ_WAIT;
            default: begin
               if (eng_done) begin
                  if (is_last) begin
                     busy_o  <= 1'b0;
                     done_o  <= 1'b1;
                     state_q <= SQ_IDLE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= SQ_LOAD;
                  end
               end
            end
         endcase
      end
   end

   p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   p_done_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(busy_o) && !busy_o));

   p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_o) && busy_o) |-> $stable(mode_q));

   p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= (mode_q ? IDX_W'(N_SHORT - 1) : IDX_W'(N_FULL - 1)));

endmodule

// File: tb/test_link_connect_seq.sv
`timescale 1ns/1ps
module test_link_connect_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       short_mode_i = 1'b0;
   logic [7:0] div_i = 8'd0;
   logic       busy_o, done_o, link_clk_o, link_dat_o, link_dat_oe_o;

   always #2.5 clk = ~clk;

   link_connect_seq i_link_connect_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_mode_i(short_mode_i),
      .div_i(div_i), .busy_o(busy_o), .done_o(done_o), .link_clk_o(link_clk_o),
      .link_dat_o(link_dat_o), .link_dat_oe_o(link_dat_oe_o)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // observed token stream: 0/1 = bit at rising edge, 2 = released slot, 100+n = escape of n toggles
   int obs [0:255];
   int n_obs;
   int exp_tok [0:255];
   int n_exp;
   int cur_div;
   int esc_run, low_cnt, low_bad, gap_cnt, gap_bad;
   logic pc, pd, po;

   always @(negedge clk) begin
      if (!rst_n) begin
         n_obs = 0; esc_run = 0; low_cnt = 0; low_bad = 0; gap_cnt = 0; gap_bad = 0;
         pc = 1'b1; pd = 1'b0; po = 1'b1;
      end else begin
         if (!link_clk_o) low_cnt++;
         if (link_clk_o && !pc) begin
            if (n_obs < 256) obs[n_obs] = po ? int'(pd) : 2;
            n_obs++;
            if (low_cnt != cur_div + 1) low_bad++;
            low_cnt = 0;
         end
         if (!link_clk_o && pc && esc_run > 0) begin
            if (n_obs < 256) obs[n_obs] = 100 + esc_run;
            n_obs++;
            esc_run = 0;
         end
         if (link_clk_o && pc && link_dat_oe_o && link_dat_o != pd) begin
            if (esc_run > 0 && gap_cnt != cur_div + 1) gap_bad++;
            esc_run++;
            gap_cnt = 0;
         end
         gap_cnt++;
         pc = link_clk_o; pd = link_dat_o; po = link_dat_oe_o;
      end
   end

   task automatic push(input int v);
      exp_tok[n_exp] = v;
      n_exp++;
   endtask

   task automatic e_raw(input int n, input int unsigned val);
      for (int i = 0; i < n; i++) push(int'((val >> i) & 1));
   endtask

   task automatic e_scan(input int n, input int unsigned tms);
      for (int i = 0; i < n; i++) begin
         push(1);
         push(int'((tms >> i) & 1));
         push(2);
      end
   endtask

   // expected stream from R1..R7 (R6 scan slots, R8 LSB first)
   task automatic build(input bit sh);
      n_exp = 0;
      push(110);                 // R1
      e_raw(22, 32'hFFFF_FFFF);  // R2
      e_raw(1, 0);
      push(107);                 // R3
      if (sh) begin              // R7
         e_raw(4, 'hC);
         e_raw(4, 'h8);
         e_raw(4, 0);
      end else begin             // R4, R5
         e_raw(4, 0);
         e_raw(4, 0);
         e_raw(24, 0);
         e_raw(4, 0);
         e_raw(9, 'h20);
         e_raw(9, 'h11);
         e_raw(9, 'h93);
         e_raw(4, 0);
         e_raw(9, 'h07);
         e_scan(1, 0);
         e_raw(4, 0);
         e_scan(6, 'h1B);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_done();
      int guard = 0;
      while (!done_o && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic compare(input bit sh);
      string tag;
      tag = sh ? "R7" : "R5";
      chk(n_obs == n_exp, {tag, " token count"}, n_obs, n_exp);
      for (int i = 0; i < n_exp && i < n_obs; i++) begin
         if (exp_tok[i] == 110) chk(obs[i] == exp_tok[i], "R1 reset escape", obs[i], exp_tok[i]);
         else if (exp_tok[i] == 107) chk(obs[i] == exp_tok[i], "R3 select escape", obs[i], exp_tok[i]);
         else if (obs[i] != exp_tok[i]) chk(1'b0, {tag, " stream bit"}, obs[i], exp_tok[i]);
      end
   endtask

   task automatic run_case(input bit sh, input int dv, input bit disturb);
      cur_div = dv;
      div_i = 8'(dv);
      short_mode_i = sh;
      do_reset();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1 && done_o == 1'b0, "R10 busy after start", int'(busy_o), 1);
      if (disturb) begin
         repeat (150) @(negedge clk);
         short_mode_i = ~sh;      // R11: must be ignored
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         chk(busy_o == 1'b1, "R11 busy kept", int'(busy_o), 1);
      end
      wait_done();
      chk(done_o == 1'b1 && busy_o == 1'b0, "R10 done at end", int'(done_o), 1);
      build(sh);
      compare(sh);
      chk(low_bad == 0, "R9 low phase length", low_bad, 0);
      chk(gap_bad == 0, "R9 escape spacing", gap_bad, 0);
   endtask

   typedef struct packed { bit sh; int dv; int edges; } vec_t;
   localparam int NV = 4;
   localparam vec_t VEC [NV] = '{
      '{sh: 1'b0, dv: 0, edges: 124},
      '{sh: 1'b0, dv: 3, edges: 124},
      '{sh: 1'b1, dv: 1, edges: 35},
      '{sh: 1'b1, dv: 5, edges: 35}
   };

   initial begin
      #(150000 * 5);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cur_div = 0;
      do_reset();
      // R12 reset state
      chk(busy_o == 1'b0, "R12 busy", int'(busy_o), 0);
      chk(done_o == 1'b0, "R12 done", int'(done_o), 0);
      chk(link_clk_o == 1'b1, "R12 clock high", int'(link_clk_o), 1);
      chk(link_dat_oe_o == 1'b1 && link_dat_o == 1'b0, "R12 data driven low",
          int'(link_dat_o), 0);

      for (int v = 0; v < NV; v++) begin
         int edges;
         run_case(VEC[v].sh, VEC[v].dv, 1'b0);
         edges = 0;
         for (int i = 0; i < n_obs && i < 256; i++) if (obs[i] < 100) edges++;
         chk(edges == VEC[v].edges, "R8 exact rising edge count", edges, VEC[v].edges); // also R2 R4 R6
      end

      // R11: stray start and mode flip mid-run
      run_case(1'b0, 2, 1'b1);
      run_case(1'b1, 2, 1'b1);

      // R10: done held until the next start
      repeat (40) @(negedge clk);
      chk(done_o == 1'b1 && busy_o == 1'b0, "R10 done held", int'(done_o), 1);
      chk(link_clk_o == 1'b1, "R8 idle clock high", int'(link_clk_o), 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0 && busy_o == 1'b1, "R10 done cleared on start", int'(done_o), 0);

      // R12: reset mid-run returns to the idle pin state
      repeat (30) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R12 reset mid-run flags", int'(busy_o), 0);
      chk(link_clk_o == 1'b1 && link_dat_oe_o == 1'b1, "R12 reset mid-run pins",
          int'(link_clk_o), 1);
      rst_n = 1'b1;
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule